// File: doc/BRIEF.md
# Double-Precision to 64-Bit Integer Converter

This block turns a 64-bit IEEE-754 double into a signed 64-bit integer. The rounding rule is chosen per operation from four choices. A separate chop input forces truncation whatever rule is selected. The result is never clamped: it is the true integer value taken modulo 2^64. Three flags travel with each result: invalid, integer overflow and inexact.

Operations enter on a valid strobe, one per cycle with no back-pressure, and leave two cycles later. The first stage sorts the operand into a class (zero, subnormal, non-finite, large or fractional) and aligns the mantissa. It splits the mantissa into an integer part and a 64-bit discarded fraction. The second stage applies the rounding increment, negates negative values and registers the outputs.

Top module: `dbl2int_cvt`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after `in_valid`, and `out_int` and the three flags belong to that same operation. After reset `out_valid`, `out_int` and every flag are 0.
- R2: An operand with exponent field (bits 62:52) and fraction field (bits 51:0) both zero gives result 0 with no flags, for either sign.
- R3: An operand whose exponent field is all ones (infinity or NaN) gives result 0 with only `flag_invalid` set.
- R4: An operand with zero exponent and nonzero fraction gives result 0 with no flags when `flush_sub` is 1. When `flush_sub` is 0 it is treated as a value whose integer part is 0 and whose discarded fraction is a single lowest-order sticky bit: inexact is raised and the rounding rule applies.
- R5: A normal operand with shift count (exponent minus 1075) of zero or more gives the mantissa, with its hidden bit restored at bit 52, shifted left by that count. Only the low 64 bits are kept, so the result is 0 when the count is 64 or more. No rounding is applied.
- R6: A shift count of 11 or more sets `flag_ovf` and `flag_inexact`. The single exception is the operand 0xC3E0000000000000, which gives 0x8000000000000000 with no flags.
- R7: With `rnd_mode` = 2'b00 (nearest-even), one is added to the magnitude when the discarded fraction is above one half. At exactly one half, the magnitude's lowest bit is added.
- R8: `rnd_mode` = 2'b01 adds nothing (toward zero). 2'b10 adds one only for a positive operand with a nonzero discarded fraction (toward plus infinity). 2'b11 adds one only for a negative operand with a nonzero discarded fraction (toward minus infinity).
- R9: When `chop` is 1, the result and flags equal those of `rnd_mode` = 2'b01, whatever `rnd_mode` holds.
- R10: A negative operand gives the two's complement of the rounded magnitude, modulo 2^64.
- R11: `flag_inexact` is set for a fractional operand exactly when its discarded fraction is nonzero. A shift count magnitude of 63 or more always counts as a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | 64 | Double-precision operand |
| rnd_mode | input | 2 | Rounding rule: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| chop | input | 1 | Force truncation |
| flush_sub | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Result strobe |
| out_int | output | 64 | Integer result, low 64 bits |
| flag_invalid | output | 1 | Non-finite operand |
| flag_ovf | output | 1 | Integer overflow |
| flag_inexact | output | 1 | Result differs from the operand value |

## Verification
The assertions assume one thing about the inputs: `in_valid` and the operand are meaningful only in the cycles after reset. Every check that relates an output to an earlier input waits until two clean cycles have passed since reset. The stimulus sweeps every exponent around the integer boundary, together with fraction patterns that put the discarded fraction below, at and above one half. Each pattern is run with both signs, every rounding rule, chop and flush. Idle gaps are inserted so that strobes are not always back to back.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;
  localparam int DW      = 64;
  localparam int EW      = 11;
  localparam int FW      = 52;
  localparam int SHW     = EW + 2;
  localparam int BIAS    = (1 << (EW - 1)) - 1;
  localparam int INT_OFS = BIAS + FW;
  localparam logic [DW-1:0] MIN_INT_BITS = 64'hC3E0_0000_0000_0000;
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_UP   = 2'b10,
    RND_DOWN = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic            neg;
    logic [DW-1:0]   mag;
    logic [DW-1:0]   rfrac;
    rnd_mode_e       mode;
    logic            inv;
    logic            ovf;
  } align_t;

  function automatic logic f_round_inc(rnd_mode_e m, logic neg, logic lsb,
                                       logic [DW-1:0] rf);
    logic inc;
    case (m)
      RND_NEAR: inc = (rf > HALF) || ((rf == HALF) && lsb);
      RND_UP:   inc = (rf != '0) && !neg;
      RND_DOWN: inc = (rf != '0) && neg;
      default:  inc = 1'b0;
    endcase
    return inc;
  endfunction

  function automatic logic [DW-1:0] f_apply_sign(logic neg, logic [DW-1:0] v);
    return neg ? (~v + 1'b1) : v;
  endfunction
endpackage

// File: rtl/dbl2int_align.sv
module dbl2int_align
  import dbl2int_pkg::*;
(
  input  logic [DW-1:0] op_bits,
  input  rnd_mode_e     mode_in,
  input  logic          chop,
  input  logic          flush_sub,
  output align_t        aln,
  output logic          ev_nonfinite,
  output logic          ev_sub_sticky,
  output logic          ev_big
);
  logic                  sgn;
  logic [EW-1:0]         ex;
  logic [FW-1:0]         fr;
  logic [DW-1:0]         mant;
  logic signed [SHW-1:0] sh;
  logic signed [SHW-1:0] nsh;

  assign sgn  = op_bits[DW-1];
  assign ex   = op_bits[DW-2:FW];
  assign fr   = op_bits[FW-1:0];
  assign mant = {{(DW-FW-1){1'b0}}, 1'b1, fr};
  assign sh   = $signed({2'b00, ex}) - SHW'(INT_OFS);
  assign nsh  = -sh;

  assign ev_nonfinite  = (ex == '1);
  assign ev_sub_sticky = (ex == '0) && (fr != '0) && !flush_sub;
  assign ev_big        = !ev_nonfinite && (ex != '0) && !sh[SHW-1];

  always_comb begin
    aln      = '0;
    aln.mode = chop ? RND_ZERO : mode_in;
    if (ev_nonfinite) begin
      aln.inv = 1'b1;
    end else if (ex == '0) begin
      if (ev_sub_sticky) begin
        aln.neg   = sgn;
        aln.rfrac = DW'(1);
      end
    end else begin
      aln.neg = sgn;
      if (ev_big) begin
        if (sh < SHW'(DW)) aln.mag = mant << sh[5:0];
        aln.ovf = (sh >= SHW'(DW - FW - 1)) && (op_bits != MIN_INT_BITS);
      end else if (nsh < SHW'(DW - 1)) begin
        aln.mag   = mant >> nsh[5:0];
        aln.rfrac = mant << (7'd64 - nsh[6:0]);
      end else begin
        aln.rfrac = DW'(1);
      end
    end
  end
endmodule

// File: rtl/dbl2int_round.sv
module dbl2int_round
  import dbl2int_pkg::*;
(
  input  align_t        aln,
  output logic [DW-1:0] res,
  output logic          inv,
  output logic          ovf,
  output logic          inexact,
  output logic          ev_round_up
);
  logic [DW-1:0] sum;

  assign ev_round_up = f_round_inc(aln.mode, aln.neg, aln.mag[0], aln.rfrac);
  assign sum         = aln.mag + DW'(ev_round_up);
  assign res         = f_apply_sign(aln.neg, sum);
  assign inv         = aln.inv;
  assign ovf         = aln.ovf;
  assign inexact     = aln.ovf || (aln.rfrac != '0);
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
  import dbl2int_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [63:0]   in_bits,
  input  logic [1:0]    rnd_mode,
  input  logic          chop,
  input  logic          flush_sub,
  output logic          out_valid,
  output logic [63:0]   out_int,
  output logic          flag_invalid,
  output logic          flag_ovf,
  output logic          flag_inexact
);
  align_t        aln_d, aln_q;
  logic          stage1_valid;
  logic          ev_nonfinite, ev_sub_sticky, ev_big, ev_round_up;
  logic [DW-1:0] res_d;
  logic          inv_d, ovf_d, inx_d;

  dbl2int_align u_align (
    .op_bits       (in_bits),
    .mode_in       (rnd_mode_e'(rnd_mode)),
    .chop          (chop),
    .flush_sub     (flush_sub),
    .aln           (aln_d),
    .ev_nonfinite  (ev_nonfinite),
    .ev_sub_sticky (ev_sub_sticky),
    .ev_big        (ev_big)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_valid <= 1'b0;
      aln_q        <= '0;
    end else begin
      stage1_valid <= in_valid;
      aln_q        <= aln_d;
    end
  end

  dbl2int_round u_round (
    .aln         (aln_q),
    .res         (res_d),
    .inv         (inv_d),
    .ovf         (ovf_d),
    .inexact     (inx_d),
    .ev_round_up (ev_round_up)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_int      <= '0;
      flag_invalid <= 1'b0;
      flag_ovf     <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      out_valid    <= stage1_valid;
      out_int      <= res_d;
      flag_invalid <= inv_d;
      flag_ovf     <= ovf_d;
      flag_inexact <= inx_d;
    end
  end
endmodule

// File: rtl/dbl2int_cvt_chk.sv
module dbl2int_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_bits,
  input logic        stage1_valid,
  input logic        out_valid,
  input logic [63:0] out_int,
  input logic        flag_invalid,
  input logic        flag_ovf,
  input logic        flag_inexact
);
  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk) begin
    if (!rst_n) warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd2);

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 2)));

  a_r1_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
    stage1_valid |=> out_valid);

  a_r2_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && ($past(in_bits[62:0], 2) == 63'd0))
      |-> (out_int == 64'd0 && !flag_invalid && !flag_ovf && !flag_inexact));

  a_r3_nonfinite: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(in_valid, 2) && ($past(in_bits[62:52], 2) == 11'h7FF))
      |-> (flag_invalid && out_int == 64'd0));

  a_r3_invalid_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |-> (!flag_ovf && !flag_inexact));

  a_r6_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_ovf) |-> flag_inexact);
endmodule

bind dbl2int_cvt dbl2int_cvt_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_bits      (in_bits),
  .stage1_valid (stage1_valid),
  .out_valid    (out_valid),
  .out_int      (out_int),
  .flag_invalid (flag_invalid),
  .flag_ovf     (flag_ovf),
  .flag_inexact (flag_inexact)
);

// File: tb/dbl2int_cvt_tb_top.sv
module dbl2int_cvt_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_bits = '0;
  logic [1:0]  rnd_mode = '0;
  logic        chop = 1'b0;
  logic        flush_sub = 1'b0;
  logic        out_valid;
  logic [63:0] out_int;
  logic        flag_invalid, flag_ovf, flag_inexact;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] q_res [64];
  logic [2:0]  q_flg [64];
  string       q_tag [64];
  int          wp = 0;
  int          rp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl2int_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .rnd_mode(rnd_mode), .chop(chop), .flush_sub(flush_sub),
    .out_valid(out_valid), .out_int(out_int), .flag_invalid(flag_invalid),
    .flag_ovf(flag_ovf), .flag_inexact(flag_inexact)
  );

  // Arithmetic model: value = m * 2^p, split on a 128-bit fixed point grid.
  task automatic ref_conv(input logic [63:0] b, input logic [1:0] md,
                          input logic ch, input logic fl,
                          output logic [63:0] r, output logic [2:0] flg);
    logic [127:0] x;
    logic [63:0]  ip, fp;
    logic         neg, up, iv, ov, ix;
    logic [52:0]  m;
    logic [1:0]   em;
    int           e, p, s;
    r = '0; iv = 0; ov = 0; ix = 0; ip = '0; fp = '0; up = 0;
    neg = b[63]; e = int'(b[62:52]); m = {1'b1, b[51:0]};
    em = ch ? 2'd1 : md;
    p = e - 1075;
    if (e == 2047) begin
      iv = 1;
    end else if (e == 0 && (b[51:0] == '0 || fl)) begin
      r = '0;
    end else if (e != 0 && p >= 0) begin
      x = (p < 128) ? ({75'd0, m} << p) : 128'd0;
      r = x[63:0];
      ov = (p >= 11) && !(neg && b[51:0] == '0 && p == 11);
      ix = ov;
      if (neg) r = 64'd0 - r;
    end else begin
      s = -p;
      if (e == 0 || s >= 64) fp = 64'd1;
      else begin
        x = {11'd0, m, 64'd0} >> s;
        ip = x[127:64];
        fp = x[63:0];
      end
      ix = (fp != '0);
      case (em)
        2'd0: up = fp[63] && ((fp[62:0] != '0) || ip[0]);
        2'd2: up = (fp != '0) && !neg;
        2'd3: up = (fp != '0) && neg;
        default: up = 0;
      endcase
      r = ip + {63'd0, up};
      if (neg) r = 64'd0 - r;
    end
    flg = {iv, ov, ix};
  endtask

  function automatic string tag_of(logic [63:0] b, logic [1:0] md, logic ch);
    int e = int'(b[62:52]);
    if (e == 2047) return "R3";
    if (b[62:0] == '0) return "R2";
    if (e == 0) return "R4";
    if (e - 1075 >= 11) return "R6";
    if (e - 1075 >= 0) return "R5";
    if (ch) return "R9";
    if (md == 2'd0) return "R7";
    return "R8";
  endfunction

  task automatic drive(input logic [63:0] b, input logic [1:0] md,
                       input logic ch, input logic fl, input string tg);
    logic [63:0] r;
    logic [2:0]  f;
    @(negedge clk);
    in_valid = 1'b1; in_bits = b; rnd_mode = md; chop = ch; flush_sub = fl;
    ref_conv(b, md, ch, fl, r, f);
    q_res[wp % 64] = r; q_flg[wp % 64] = f; q_tag[wp % 64] = tg;
    wp++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_cmp++;
      if (rp == wp) begin
        n_bad++;
        $display("FAIL R1: unexpected out_valid, got 1 expected 0");
      end else begin
        if (out_int !== q_res[rp % 64] ||
            {flag_invalid, flag_ovf, flag_inexact} !== q_flg[rp % 64]) begin
          n_bad++;
          $display("FAIL %s: item %0d got %h flags %b expected %h flags %b",
                   q_tag[rp % 64], rp, out_int,
                   {flag_invalid, flag_ovf, flag_inexact},
                   q_res[rp % 64], q_flg[rp % 64]);
        end
        rp++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [51:0] fpat [6];
    int          nvec;
    fpat[0] = 52'h0; fpat[1] = 52'h1; fpat[2] = 52'h8000000000000;
    fpat[3] = 52'hFFFFFFFFFFFFF; fpat[4] = 52'h4000000000001;
    fpat[5] = 52'h0000000000080;
    nvec = 0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (out_valid !== 1'b0 || out_int !== '0 ||
        {flag_invalid, flag_ovf, flag_inexact} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1: reset state got v=%b %h %b expected 0 0 000",
               out_valid, out_int, {flag_invalid, flag_ovf, flag_inexact});
    end

    // R1: latency of a single isolated operation (1.0 -> 1)
    drive(64'h3FF0000000000000, 2'd0, 1'b0, 1'b0, "R1");
    idle();
    n_cmp++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: out_valid one cycle after strobe got 1 expected 0");
    end
    @(negedge clk);
    repeat (3) @(negedge clk);

    // Directed corners
    drive(64'h4004000000000000, 2'd0, 1'b0, 1'b0, "R7");  // 2.5 -> 2
    drive(64'h400C000000000000, 2'd0, 1'b0, 1'b0, "R7");  // 3.5 -> 4
    drive(64'hC004000000000000, 2'd0, 1'b0, 1'b0, "R10"); // -2.5 -> -2
    drive(64'hBFF8000000000000, 2'd3, 1'b0, 1'b0, "R10"); // -1.5 down -> -2
    drive(64'h3FF8000000000000, 2'd1, 1'b0, 1'b0, "R11"); // 1.5 inexact
    drive(64'h4000000000000000, 2'd2, 1'b0, 1'b0, "R11"); // 2.0 exact
    drive(64'hC3E0000000000000, 2'd0, 1'b0, 1'b0, "R6");  // -2^63 exempt
    drive(64'h43E0000000000000, 2'd0, 1'b0, 1'b0, "R6");  // +2^63 overflows
    drive(64'h0000000000000001, 2'd3, 1'b0, 1'b0, "R4");
    drive(64'h8000000000000001, 2'd3, 1'b0, 1'b0, "R4");  // -> all ones
    drive(64'h8000000000000001, 2'd3, 1'b0, 1'b1, "R4");  // flushed
    drive(64'h7FF8000000000000, 2'd2, 1'b0, 1'b0, "R3");
    drive(64'h8000000000000000, 2'd2, 1'b0, 1'b0, "R2");
    drive(64'h3FE8000000000000, 2'd2, 1'b1, 1'b0, "R9");  // 0.75 chop -> 0
    idle();

    // Sweep
    for (int ei = 0; ei < 99; ei++) begin
      int e;
      if (ei < 91) e = 1000 + ei;
      else begin
        case (ei)
          91: e = 0;  92: e = 1;  93: e = 100; 94: e = 1100;
          95: e = 1500; 96: e = 2046; 97: e = 2047; default: e = 1139;
        endcase
      end
      for (int fi = 0; fi < 6; fi++)
        for (int sg = 0; sg < 2; sg++)
          for (int md = 0; md < 4; md++)
            for (int ch = 0; ch < 2; ch++)
              for (int fl = 0; fl < 2; fl++) begin
                logic [63:0] b;
                b = {sg[0], e[10:0], fpat[fi]};
                drive(b, md[1:0], ch[0], fl[0], tag_of(b, md[1:0], ch[0]));
                nvec++;
                if (nvec % 7 == 0) idle();
              end
    end
    idle();
    repeat (6) @(negedge clk);
    n_cmp++;
    if (rp != wp) begin
      n_bad++;
      $display("FAIL R1: results received got %0d expected %0d", rp, wp);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule